// File: doc/BRIEF.md
# Indexed Colour Palette with Sequenced Register Loading

This block is a 256-entry colour lookup table. Each entry stores an 8-bit red, an 8-bit green and an 8-bit blue value. A processor fills the table through a small register window on a 32-bit write bus. The display pipeline reads the table through a separate lookup port: it presents an 8-bit pixel code and gets the matching colour triple back one clock later.

Software picks an entry by writing a pointer register. It then writes colour bytes to one data register. A three-step sequencer routes successive data writes to red, then green, then blue. After the blue write, the pointer moves on to the next entry. A whole palette can therefore be streamed as one pointer write followed by a run of data writes.

Every completed data write produces a one-cycle change pulse. Downstream logic uses this pulse to schedule a full redraw.

Top module: `pal_dac`

## Requirements
- R1: A full-word write to offset 0x0 loads the entry pointer from bits 31:24 of the word and returns the sequencer to its red step. This holds even in the middle of a triple.
- R2: A full-word write to offset 0x4 stores bits 31:24 of the word into one component of the entry selected by the pointer. The sequencer steps red, green, blue in that order, one step per data write.
- R3: The data write that stores blue returns the sequencer to red and increments the pointer by one. The pointer wraps from 255 to 0.
- R4: A write whose byte enables `reg_be_i` are not all four set (4'b1111) is ignored. It changes no entry, no pointer, no sequencer step and raises no change pulse.
- R5: A write to any window offset other than 0x0 and 0x4 is ignored. This includes offsets that are not a multiple of four.
- R6: `reg_rdata_o` is zero at all times.
- R7: Reset has these effects:
  - Every component of entries 0 to 254 becomes 0x00.
  - Entry 255 becomes 0xFF/0xFF/0xFF.
  - The pointer becomes 0 and the sequencer step becomes red.
  - The lookup outputs become 0.
- R8: The lookup port is registered. The colour of the entry presented on `pix_idx_i` at one rising edge appears on `pix_red_o`, `pix_grn_o` and `pix_blu_o` after that edge.
- R9: `pal_changed_o` is high for exactly the cycle that follows each accepted data write, and is low otherwise.
- R10: When a lookup and a data write address the same entry at the same edge, the lookup returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Byte offset within the register window |
| reg_be_i | input | 4 | Byte enables of the write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, always zero |
| pix_idx_i | input | 8 | Lookup pixel code |
| pix_red_o | output | 8 | Looked-up red |
| pix_grn_o | output | 8 | Looked-up green |
| pix_blu_o | output | 8 | Looked-up blue |
| pal_changed_o | output | 1 | One-cycle pulse after each accepted data write |

## Verification
The assertions check the following on every cycle:
- how the pointer loads, advances and holds;
- the red-to-green step of the sequencer;
- the suppression of partial-width writes;
- the rule that at most one colour bank is written per edge.

Only the bench scenarios can show:
- that stored bytes land in the right entry and component;
- the reset contents of the table;
- the 255-to-0 wrap, seen through the lookup port;
- the old-value result when a lookup and a write hit the same entry;
- that ignored writes leave every colour unchanged.

The bench compares each lookup against a model that it updates from its own stimulus.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;

  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } comp_sel_e;

  localparam int unsigned NUM_COMP = 3;

endpackage

// File: rtl/pal_reg_seq.sv
module pal_reg_seq
  import pal_dac_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W/8-1:0]   be_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [IDX_W-1:0]      idx_o,
  output logic [NUM_COMP-1:0]   comp_we_o,
  output logic [COMP_W-1:0]     comp_data_o,
  output logic                  upd_o
);

  localparam int unsigned FIELD_W = (IDX_W > COMP_W) ? IDX_W : COMP_W;
  localparam logic [ADDR_W-1:0] OFS_INDEX = '0;
  localparam logic [ADDR_W-1:0] OFS_DATA  = ADDR_W'(4);

  logic             full_word;
  logic             hit_idx;
  logic             hit_dat;
  logic [IDX_W-1:0] idx_q;
  comp_sel_e        seq_q;
  logic [1:0]       seq_bits;
  logic             upd_q;
  logic             unused_low;

  // Only complete words are accepted
  assign full_word   = &be_i;
  assign hit_idx     = wr_i && full_word && (addr_i == OFS_INDEX);
  assign hit_dat     = wr_i && full_word && (addr_i == OFS_DATA);
  assign comp_data_o = wdata_i[DATA_W-1 -: COMP_W];
  assign seq_bits    = seq_q;
  assign unused_low  = ^wdata_i[DATA_W-FIELD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      seq_q <= COMP_RED;
    end else if (hit_idx) begin
      idx_q <= wdata_i[DATA_W-1 -: IDX_W];
      seq_q <= COMP_RED;
    end else if (hit_dat) begin
      unique case (seq_q)
        COMP_RED: seq_q <= COMP_GRN;
        COMP_GRN: seq_q <= COMP_BLU;
        COMP_BLU: begin
          seq_q <= COMP_RED;
          idx_q <= idx_q + 1'b1;
        end
        default:  seq_q <= COMP_RED;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_we
    assign comp_we_o[c] = hit_dat && (seq_bits == 2'(c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= hit_dat;
  end

  assign idx_o = idx_q;
  assign upd_o = upd_q;

  AST_IDX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_idx |=> (idx_q == $past(wdata_i[DATA_W-1 -: IDX_W])) && (seq_q == COMP_RED)); // R1

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_dat && seq_q == COMP_RED) |=> (seq_q == COMP_GRN)); // R2

  AST_IDX_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_dat && seq_q == COMP_BLU) |=>
      (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (seq_q == COMP_RED)); // R3

  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_idx && !(hit_dat && seq_q == COMP_BLU)) |=> $stable(idx_q)); // R4

  AST_NO_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !(&be_i)) |=> !upd_o); // R4

endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [COMP_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [COMP_W-1:0] rdata_o
);

  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [COMP_W-1:0] mem_q [ENTRIES];
  logic [COMP_W-1:0] rdata_q;

  // Read-before-write: the lookup samples the old entry at the write edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) begin
        mem_q[e] <= (e == ENTRIES - 1) ? '1 : '0;
      end
      rdata_q <= '0;
    end else begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
      rdata_q <= mem_q[raddr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_dac_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W/8-1:0] reg_be_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [IDX_W-1:0]    pix_idx_i,
  output logic [COMP_W-1:0]   pix_red_o,
  output logic [COMP_W-1:0]   pix_grn_o,
  output logic [COMP_W-1:0]   pix_blu_o,
  output logic                pal_changed_o
);

  logic [IDX_W-1:0]              wr_idx;
  logic [NUM_COMP-1:0]           comp_we;
  logic [COMP_W-1:0]             comp_data;
  logic [NUM_COMP-1:0][COMP_W-1:0] comp_rd;

  pal_reg_seq #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .COMP_W (COMP_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .be_i        (reg_be_i),
    .wdata_i     (reg_wdata_i),
    .idx_o       (wr_idx),
    .comp_we_o   (comp_we),
    .comp_data_o (comp_data),
    .upd_o       (pal_changed_o)
  );

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_bank
    pal_bank #(
      .IDX_W  (IDX_W),
      .COMP_W (COMP_W)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (comp_we[c]),
      .waddr_i (wr_idx),
      .wdata_i (comp_data),
      .raddr_i (pix_idx_i),
      .rdata_o (comp_rd[c])
    );
  end

  assign pix_red_o   = comp_rd[COMP_RED];
  assign pix_grn_o   = comp_rd[COMP_GRN];
  assign pix_blu_o   = comp_rd[COMP_BLU];
  assign reg_rdata_o = '0;

  AST_ONE_COMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(comp_we)); // R2

  AST_CHG_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_changed_o |-> $past(|comp_we)); // R9

endmodule

// File: tb/pal_dac_bench.sv
module pal_dac_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  pidx = '0;
  logic [31:0] rdata;
  logic [7:0]  pr, pg, pb;
  logic        pchg;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx;
  int         m_seq;

  always #2 clk = ~clk;

  pal_dac u_pal_dac (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .reg_wr_i      (wr),
    .reg_addr_i    (addr),
    .reg_be_i      (be),
    .reg_wdata_i   (wdata),
    .reg_rdata_o   (rdata),
    .pix_idx_i     (pidx),
    .pix_red_o     (pr),
    .pix_grn_o     (pg),
    .pix_blu_o     (pb),
    .pal_changed_o (pchg)
  );

  function automatic logic [31:0] mk_word(logic [7:0] top);
    return {top, 24'($urandom)};
  endfunction

  function automatic bit accepted(logic [5:0] a, logic [3:0] e);
    return (e == 4'hF) && (a == 6'h0 || a == 6'h4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_r[i] = (i == 255) ? 8'hFF : 8'h00;
      m_g[i] = m_r[i];
      m_b[i] = m_r[i];
    end
    m_idx = '0;
    m_seq = 0;
  endtask

  task automatic model_write(logic [5:0] a, logic [31:0] d, logic [3:0] e);
    if (accepted(a, e)) begin
      if (a == 6'h0) begin
        m_idx = d[31:24];
        m_seq = 0;
      end else begin
        case (m_seq)
          0: m_r[m_idx] = d[31:24];
          1: m_g[m_idx] = d[31:24];
          default: m_b[m_idx] = d[31:24];
        endcase
        if (m_seq == 2) begin
          m_seq = 0;
          m_idx = m_idx + 8'd1;
        end else begin
          m_seq = m_seq + 1;
        end
      end
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [31:0] d, logic [3:0] e);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d; be = e;
    @(posedge clk);
    #1;
    model_write(a, d, e);
    check("R9 change pulse", 32'(pchg), 32'(accepted(a, e) && a == 6'h4));
    check("R6 read data", rdata, 32'h0);
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic lookup(logic [7:0] i, string req);
    @(negedge clk);
    pidx = i;
    @(posedge clk);
    #1;
    check(req, 32'(pr), 32'(m_r[i]));
    check(req, 32'(pg), 32'(m_g[i]));
    check(req, 32'(pb), 32'(m_b[i]));
    check("R9 no pulse when idle", 32'(pchg), 32'h0);
  endtask

  task automatic triple(logic [7:0] r, logic [7:0] g, logic [7:0] b);
    bus_write(6'h4, mk_word(r), 4'hF);
    bus_write(6'h4, mk_word(g), 4'hF);
    bus_write(6'h4, mk_word(b), 4'hF);
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R7 lookup red after reset", 32'(pr), 32'h0);
    check("R7 change pulse after reset", 32'(pchg), 32'h0);
    check("R6 read data in reset", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    lookup(8'd255, "R7 entry 255 white");
    lookup(8'd0, "R7 entry 0 black");
    lookup(8'd128, "R7 entry 128 black");

    // Pointer and step clear at reset: first triple lands in entry 0
    triple(8'h11, 8'h22, 8'h33);
    lookup(8'd0, "R7 R2 first triple in entry 0");
    lookup(8'd1, "R3 entry 1 untouched");
    bus_write(6'h4, mk_word(8'h44), 4'hF);
    lookup(8'd1, "R3 pointer advanced to 1");

    bus_write(6'h0, mk_word(8'hFE), 4'hF);
    triple(8'hA1, 8'hA2, 8'hA3);
    triple(8'hB1, 8'hB2, 8'hB3);
    triple(8'hC1, 8'hC2, 8'hC3);
    lookup(8'hFE, "R1 R2 entry FE");
    lookup(8'hFF, "R3 entry FF");
    lookup(8'h00, "R3 wrap to entry 0");

    // Pointer write mid-triple restarts at red
    bus_write(6'h0, mk_word(8'd10), 4'hF);
    bus_write(6'h4, mk_word(8'h5A), 4'hF);
    bus_write(6'h0, mk_word(8'd20), 4'hF);
    triple(8'h61, 8'h62, 8'h63);
    lookup(8'd10, "R1 partial triple");
    lookup(8'd20, "R1 restart at red");

    // Partial byte enables ignored
    bus_write(6'h0, mk_word(8'd40), 4'hF);
    bus_write(6'h4, mk_word(8'h77), 4'b0111);
    bus_write(6'h4, mk_word(8'h78), 4'b1000);
    bus_write(6'h0, mk_word(8'd90), 4'b1110);
    triple(8'h81, 8'h82, 8'h83);
    lookup(8'd40, "R4 partial writes ignored");
    lookup(8'd90, "R4 partial pointer ignored");

    // Other offsets ignored
    bus_write(6'h0, mk_word(8'd50), 4'hF);
    bus_write(6'h8, mk_word(8'h99), 4'hF);
    bus_write(6'h5, mk_word(8'h98), 4'hF);
    bus_write(6'h3C, mk_word(8'h97), 4'hF);
    bus_write(6'h1, mk_word(8'd60), 4'hF);
    triple(8'h91, 8'h92, 8'h93);
    lookup(8'd50, "R5 other offsets ignored");
    lookup(8'd60, "R5 misaligned pointer ignored");

    // Lookup and write to same entry at the same edge
    bus_write(6'h0, mk_word(8'd70), 4'hF);
    @(negedge clk);
    pidx = 8'd70; wr = 1'b1; addr = 6'h4; be = 4'hF; wdata = mk_word(8'hEE);
    @(posedge clk);
    #1;
    check("R10 old red on collision", 32'(pr), 32'(m_r[70]));
    model_write(6'h4, wdata, 4'hF);
    @(negedge clk);
    wr = 1'b0; be = '0;
    lookup(8'd70, "R10 new red next cycle");

    // Random mix
    for (int k = 0; k < 600; k++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel == 0) bus_write(6'h0, mk_word(8'($urandom)), 4'hF);
      else if (sel <= 5) bus_write(6'h4, mk_word(8'($urandom)), 4'hF);
      else if (sel == 6) bus_write(6'h4, mk_word(8'($urandom)), 4'($urandom_range(0, 14)));
      else if (sel == 7) bus_write(6'($urandom_range(8, 63)), mk_word(8'($urandom)), 4'hF);
      else lookup(8'($urandom), "R2 R8 random lookup");
    end
    for (int i = 0; i < 256; i += 17) lookup(8'(i), "R8 final sweep");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule